// File: doc/BRIEF.md
# Digital Volume Stage with Static-Data Auto-Mute

This block scales two channels of signed audio samples, A and B, by a gain chosen from an 8-bit attenuation code. The code works in 0.5 dB steps. The largest gain is about +24 dB and the smallest is -103 dB. One code value silences the output completely. A shared master code and a trim code for each channel add together to form the code a channel uses. Each product is clipped to the sample width. The results are registered and appear one clock after the sample strobe.

Each channel also watches its own input for long runs of the same static word, either all zeros or all ones. When such a run reaches a parameterised length and auto-mute is enabled, the block silences that channel without help. A single non-static sample brings the channel back on that same sample. A channel can also be silenced directly through a mute input. Each output has a flag that reports whether that channel is silenced, for whatever reason.

Top module: `vam_volume`

## Requirements
- R1: The output equals the input times 10^((24 - 0.5*code)/20), within 5 % plus 2 LSB, where code is the effective code. Code 0x30 passes the sample through exactly (0 dB). Code 0x2A gives +3 dB and code 0x00 about +24 dB.
- R2: Effective code 0xFE gives about -103 dB. A master or trim code of 0xFF drives that channel's output to 0 and raises its muted flag.
- R3: The effective code is master plus trim, clamped at 0xFE when the sum is larger.
- R4: A scaled result above 2^(W-1)-1 or below -2^(W-1) is clipped to that limit.
- R5: On the clock edge that samples in_valid high, the outputs, flags and out_valid update. For one cycle after that edge, out_valid is high. Outputs and flags hold between strobes, even when the codes change.
- R6: When auto-mute is enabled, a channel is silenced (output 0, flag 1) on the RUN_LEN-th (default 8192) consecutive strobed sample that is the same static word. A static word is all bits 0 or all bits 1. Before that sample, the channel is not silenced.
- R7: A non-static sample on a silenced channel releases auto-mute on that same sample, and that sample is output scaled.
- R8: Static-run detection and auto-mute work separately on each channel.
- R9: A change of sample value starts a new run. For example, switching from all zeros to all ones restarts the count at one. With automute_en low, no channel is auto-muted, but the run count keeps growing up to RUN_LEN. Once enabled, an already full run silences the channel on the next static sample.
- R10: A high mute input forces that channel's output to 0 and raises its flag. The other channel is not affected.
- R11: After reset, out_a, out_b, out_valid, muted_a and muted_b are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Sample strobe |
| in_a | input | SAMPLE_W | Channel A sample, two's complement |
| in_b | input | SAMPLE_W | Channel B sample, two's complement |
| master_vol | input | 8 | Shared attenuation code, 0.5 dB per step from +24 dB |
| trim_a | input | 8 | Extra attenuation for A, 0.5 dB per step |
| trim_b | input | 8 | Extra attenuation for B, 0.5 dB per step |
| mute_a | input | 1 | Forces A silent |
| mute_b | input | 1 | Forces B silent |
| automute_en | input | 1 | Enables static-data auto-mute |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_a | output | SAMPLE_W | Scaled channel A |
| out_b | output | SAMPLE_W | Scaled channel B |
| muted_a | output | 1 | Channel A silenced |
| muted_b | output | 1 | Channel B silenced |

## Verification
The gain path is driven with a sweep of master codes, using one positive and one negative sample. The sweep compares the result against a real-valued decibel model, and at 0 dB it requires an exact match. This separates errors in the step mantissas from errors in the octave shift. Trim-plus-master sums below and above the floor show whether the clamp works. Full-scale inputs at +24 dB show clipping at both rails. For auto-mute, channel A is held at zero for exactly one sample less than the run length and then for the full run, while channel B carries a steady non-static value. This tells a count that is off by one apart from a correct one, and shows that the channels are independent. A zero run followed by an all-ones run, and a run made while the enable is low, separate restarting the count on a value change from ignoring that change.

// File: rtl/vam_pkg.sv
package vam_pkg;

   localparam int CODE_W        = 8;
   localparam int MANT_FRAC     = 16;
   localparam int MANT_W        = MANT_FRAC + 1;
   localparam int STEPS_PER_OCT = 12;
   localparam int UNITY_OCT     = 4;
   localparam int OCT_W         = 5;

   localparam logic [CODE_W-1:0] CODE_SILENT = 8'hFF;
   localparam logic [CODE_W-1:0] CODE_FLOOR  = 8'hFE;

   typedef struct packed {
      logic [MANT_W-1:0] mant;
      logic [OCT_W-1:0]  oct;
      logic              silent;
   } gain_t;

   // 10^(-r/40) in unsigned 1.16 format, r = 0..11 half-dB steps
   function automatic logic [MANT_W-1:0] step_mant(input logic [3:0] r);
      logic [MANT_W-1:0] m;
      case (r)
         4'd0:    m = 17'd65536;
         4'd1:    m = 17'd61870;
         4'd2:    m = 17'd58409;
         4'd3:    m = 17'd55142;
         4'd4:    m = 17'd52057;
         4'd5:    m = 17'd49145;
         4'd6:    m = 17'd46396;
         4'd7:    m = 17'd43801;
         4'd8:    m = 17'd41350;
         4'd9:    m = 17'd39037;
         4'd10:   m = 17'd36854;
         default: m = 17'd34792;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/vam_gain_map.sv
module vam_gain_map
   import vam_pkg::*;
(
   input  logic [CODE_W-1:0] master,
   input  logic [CODE_W-1:0] trim,
   output gain_t             gain
);

   logic [CODE_W:0]   sum;
   logic [CODE_W-1:0] eff;
   logic [CODE_W-1:0] oct_full;
   logic [CODE_W-1:0] step_full;

   always_comb begin
      sum       = {1'b0, master} + {1'b0, trim};
      eff       = (sum > {1'b0, CODE_FLOOR}) ? CODE_FLOOR : sum[CODE_W-1:0];
      oct_full  = eff / CODE_W'(STEPS_PER_OCT);
      step_full = eff % CODE_W'(STEPS_PER_OCT);
      gain.mant   = step_mant(step_full[3:0]);
      gain.oct    = oct_full[OCT_W-1:0];
      gain.silent = (master == CODE_SILENT) || (trim == CODE_SILENT);
   end

endmodule

// File: rtl/vam_scaler.sv
module vam_scaler
   import vam_pkg::*;
#(
   parameter int SAMPLE_W = 24
) (
   input  logic signed [SAMPLE_W-1:0] sample,
   input  gain_t                      gain,
   output logic signed [SAMPLE_W-1:0] result
);

   localparam int PW = SAMPLE_W + MANT_W + 1 + UNITY_OCT;
   localparam logic signed [PW-1:0] HI = {{(PW-SAMPLE_W+1){1'b0}}, {(SAMPLE_W-1){1'b1}}};
   localparam logic signed [PW-1:0] LO = ~HI;

   logic signed [PW-1:0] prod;
   logic signed [PW-1:0] shifted;

   always_comb begin
      prod    = $signed({{(PW-SAMPLE_W){sample[SAMPLE_W-1]}}, sample})
              * $signed({{(PW-MANT_W){1'b0}}, gain.mant});
      shifted = (prod <<< UNITY_OCT) >>> (MANT_FRAC + int'(gain.oct));
      if (shifted > HI)      result = HI[SAMPLE_W-1:0];
      else if (shifted < LO) result = LO[SAMPLE_W-1:0];
      else                   result = shifted[SAMPLE_W-1:0];
   end

endmodule

// File: rtl/vam_static_det.sv
module vam_static_det #(
   parameter int SAMPLE_W = 24,
   parameter int RUN_LEN  = 8192
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                strobe,
   input  logic [SAMPLE_W-1:0] sample,
   input  logic                enable,
   output logic                hit
);

   localparam int CW = $clog2(RUN_LEN + 1);
   localparam logic [CW-1:0] FULL = CW'(RUN_LEN);

   logic [SAMPLE_W-1:0] prev_q;
   logic [CW-1:0]       cnt_q;
   logic [CW-1:0]       cnt_d;
   logic                is_static;

   always_comb begin
      is_static = (sample == '0) || (sample == '1);
      if (is_static && sample == prev_q)
         cnt_d = (cnt_q == FULL) ? FULL : cnt_q + 1'b1;
      else if (is_static)
         cnt_d = CW'(1);
      else
         cnt_d = '0;
      hit = enable && (cnt_d == FULL);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         cnt_q  <= '0;
      end else if (strobe) begin
         prev_q <= sample;
         cnt_q  <= cnt_d;
      end
   end

endmodule

// File: rtl/vam_volume.sv
module vam_volume
   import vam_pkg::*;
#(
   parameter int SAMPLE_W = 24,
   parameter int RUN_LEN  = 8192
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       in_valid,
   input  logic signed [SAMPLE_W-1:0] in_a,
   input  logic signed [SAMPLE_W-1:0] in_b,
   input  logic [7:0]                 master_vol,
   input  logic [7:0]                 trim_a,
   input  logic [7:0]                 trim_b,
   input  logic                       mute_a,
   input  logic                       mute_b,
   input  logic                       automute_en,
   output logic                       out_valid,
   output logic signed [SAMPLE_W-1:0] out_a,
   output logic signed [SAMPLE_W-1:0] out_b,
   output logic                       muted_a,
   output logic                       muted_b
);

   localparam int NUM_CH = 2;

   if (SAMPLE_W < 8 || SAMPLE_W > 32) begin : g_bad_width
      $error("vam_volume: SAMPLE_W must lie in 8..32");
   end
   if (RUN_LEN < 2) begin : g_bad_run
      $error("vam_volume: RUN_LEN must be at least 2");
   end

   logic signed [SAMPLE_W-1:0] samp   [NUM_CH];
   logic [CODE_W-1:0]          trim   [NUM_CH];
   logic                       manual [NUM_CH];
   logic signed [SAMPLE_W-1:0] res_q  [NUM_CH];
   logic                       flag_q [NUM_CH];
   logic                       valid_q;

   assign samp[0]   = in_a;
   assign samp[1]   = in_b;
   assign trim[0]   = trim_a;
   assign trim[1]   = trim_b;
   assign manual[0] = mute_a;
   assign manual[1] = mute_b;

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      gain_t                      gain;
      logic signed [SAMPLE_W-1:0] scaled;
      logic                       run_hit;
      logic                       silence;

      vam_gain_map u_map (
         .master (master_vol),
         .trim   (trim[ch]),
         .gain   (gain)
      );

      vam_scaler #(.SAMPLE_W(SAMPLE_W)) u_scale (
         .sample (samp[ch]),
         .gain   (gain),
         .result (scaled)
      );

      vam_static_det #(.SAMPLE_W(SAMPLE_W), .RUN_LEN(RUN_LEN)) u_det (
         .clk    (clk),
         .rst_n  (rst_n),
         .strobe (in_valid),
         .sample (samp[ch]),
         .enable (automute_en),
         .hit    (run_hit)
      );

      assign silence = gain.silent || manual[ch] || run_hit;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            res_q[ch]  <= '0;
            flag_q[ch] <= 1'b0;
         end else if (in_valid) begin
            res_q[ch]  <= silence ? '0 : scaled;
            flag_q[ch] <= silence;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) valid_q <= 1'b0;
      else        valid_q <= in_valid;
   end

   assign out_valid = valid_q;
   assign out_a     = res_q[0];
   assign out_b     = res_q[1];
   assign muted_a   = flag_q[0];
   assign muted_b   = flag_q[1];

endmodule

// File: rtl/vam_volume_chk.sv
module vam_volume_chk #(
   parameter int SAMPLE_W = 24
) (
   input logic                clk,
   input logic                rst_n,
   input logic                in_valid,
   input logic [SAMPLE_W-1:0] in_a,
   input logic [7:0]          master_vol,
   input logic [7:0]          trim_a,
   input logic [7:0]          trim_b,
   input logic                mute_a,
   input logic                automute_en,
   input logic                out_valid,
   input logic [SAMPLE_W-1:0] out_a,
   input logic [SAMPLE_W-1:0] out_b,
   input logic                muted_a,
   input logic                muted_b
);

   logic a_free;
   assign a_free = !mute_a && master_vol != 8'hFF && trim_a != 8'hFF;

   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid)); // R5

   AST_HOLD_A: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_a) && $stable(muted_a)); // R5

   AST_HOLD_B: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_b) && $stable(muted_b)); // R5

   AST_SILENT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && master_vol == 8'hFF |=> muted_a && muted_b && out_a == '0 && out_b == '0); // R2

   AST_MUTED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      muted_a |-> out_a == '0); // R10

   AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && a_free && in_a != '0 && in_a != '1 |=> !muted_a); // R7

   AST_AUTOMUTE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && a_free && !automute_en |=> !muted_a); // R9

endmodule

bind vam_volume vam_volume_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .in_a        (in_a),
   .master_vol  (master_vol),
   .trim_a      (trim_a),
   .trim_b      (trim_b),
   .mute_a      (mute_a),
   .automute_en (automute_en),
   .out_valid   (out_valid),
   .out_a       (out_a),
   .out_b       (out_b),
   .muted_a     (muted_a),
   .muted_b     (muted_b)
);

// File: tb/vam_volume_test.sv
`timescale 1ns/1ps
module vam_volume_test;

   localparam int W   = 24;
   localparam int RUN = 8192;
   localparam longint MAXS = 64'sd8388607;
   localparam longint MINS = -64'sd8388608;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic signed [W-1:0] in_a = '0, in_b = '0;
   logic [7:0] master_vol = 8'h30, trim_a = 8'h00, trim_b = 8'h00;
   logic mute_a = 1'b0, mute_b = 1'b0, automute_en = 1'b1;
   logic out_valid, muted_a, muted_b;
   logic signed [W-1:0] out_a, out_b;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   vam_volume #(.SAMPLE_W(W), .RUN_LEN(RUN)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
      .master_vol(master_vol), .trim_a(trim_a), .trim_b(trim_b),
      .mute_a(mute_a), .mute_b(mute_b), .automute_en(automute_en),
      .out_valid(out_valid), .out_a(out_a), .out_b(out_b),
      .muted_a(muted_a), .muted_b(muted_b));

   task automatic check_eq(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic longint model(input longint x, input int code);
      real y;
      y = real'(x) * (10.0 ** ((24.0 - 0.5 * real'(code)) / 20.0));
      if (y > real'(MAXS)) return MAXS;
      if (y < real'(MINS)) return MINS;
      return longint'(y);
   endfunction

   task automatic check_near(input string req, input longint act, input longint x, input int code);
      longint e;
      real tol, d;
      e = model(x, code);
      tol = 2.0 + 0.05 * ((e < 0) ? -real'(e) : real'(e));
      d = real'(act - e);
      if (d < 0.0) d = -d;
      checks++;
      if (d > tol) begin
         errors++;
         $display("FAIL %s code %0d actual %0d expected %0d", req, code, act, e);
      end
   endtask

   task automatic send(input logic signed [W-1:0] a, input logic signed [W-1:0] b);
      @(negedge clk);
      in_a = a; in_b = b; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic stream(input int n, input logic signed [W-1:0] a, input logic signed [W-1:0] b);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_a = a; in_b = b; in_valid = 1'b1;
      end
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic t_reset;
      check_eq("R11 out_a", longint'(out_a), 0);
      check_eq("R11 out_b", longint'(out_b), 0);
      check_eq("R11 out_valid", longint'(out_valid), 0);
      check_eq("R11 muted_a", longint'(muted_a), 0);
      check_eq("R11 muted_b", longint'(muted_b), 0);
   endtask

   task automatic t_gain;
      int codes [7] = '{8'h00, 8'h2A, 8'h30, 8'h31, 8'h60, 8'hA0, 8'hFE};
      trim_a = 0; trim_b = 0;
      foreach (codes[i]) begin
         master_vol = 8'(codes[i]);
         send(24'sd100000, -24'sd250000);
         check_near("R1 gain A", longint'(out_a), 100000, codes[i]);
         check_near("R1 gain B", longint'(out_b), -250000, codes[i]);
      end
      master_vol = 8'h30;
      send(24'sd1234567, -24'sd7654321);
      check_eq("R1 unity A exact", longint'(out_a), 1234567);
      check_eq("R1 unity B exact", longint'(out_b), -7654321);
      master_vol = 8'hFE;
      send(24'sd8388607, -24'sd8388607);
      check_near("R2 floor A", longint'(out_a), 8388607, 254);
      check_eq("R2 floor not muted", longint'(muted_a), 0);
   endtask

   task automatic t_hold;
      logic signed [W-1:0] keep;
      master_vol = 8'h30;
      send(24'sd4321, 24'sd99);
      check_eq("R5 out_valid pulse", longint'(out_valid), 1);
      keep = out_a;
      master_vol = 8'h00; mute_a = 1'b1;
      repeat (3) @(negedge clk);
      check_eq("R5 hold value", longint'(out_a), longint'(keep));
      check_eq("R5 hold flag", longint'(muted_a), 0);
      check_eq("R5 out_valid low", longint'(out_valid), 0);
      mute_a = 1'b0; master_vol = 8'h30;
   endtask

   task automatic t_trim;
      master_vol = 8'h30; trim_a = 8'h0C; trim_b = 8'h00;
      send(24'sd200000, 24'sd200000);
      check_near("R3 trim sum A", longint'(out_a), 200000, 8'h3C);
      check_eq("R3 trim B untouched", longint'(out_b), 200000);
      master_vol = 8'h80; trim_a = 8'hF0;
      send(24'sd8388607, 24'sd8388607);
      check_near("R3 clamp A", longint'(out_a), 8388607, 254);
      check_eq("R3 clamp not muted", longint'(muted_a), 0);
      trim_a = 0;
   endtask

   task automatic t_silent_code;
      master_vol = 8'hFF;
      send(24'sd5000, -24'sd5000);
      check_eq("R2 FF A zero", longint'(out_a), 0);
      check_eq("R2 FF B zero", longint'(out_b), 0);
      check_eq("R2 FF flags", longint'({muted_a, muted_b}), 3);
      master_vol = 8'h30; trim_b = 8'hFF;
      send(24'sd5000, -24'sd5000);
      check_eq("R2 trim FF B", longint'(out_b), 0);
      check_eq("R2 trim FF A ok", longint'(out_a), 5000);
      check_eq("R2 trim FF flags", longint'({muted_a, muted_b}), 1);
      trim_b = 0;
   endtask

   task automatic t_saturate;
      master_vol = 8'h00;
      send(24'sd2000000, -24'sd2000000);
      check_eq("R4 clip high", longint'(out_a), MAXS);
      check_eq("R4 clip low", longint'(out_b), MINS);
      master_vol = 8'h30;
   endtask

   task automatic t_manual;
      mute_a = 1'b1;
      send(24'sd777, 24'sd888);
      check_eq("R10 manual A zero", longint'(out_a), 0);
      check_eq("R10 manual A flag", longint'(muted_a), 1);
      check_eq("R10 B unaffected", longint'(out_b), 888);
      mute_a = 1'b0;
   endtask

   task automatic t_automute;
      master_vol = 8'h30; automute_en = 1'b1;
      send(24'sd7, 24'sd5);
      stream(RUN - 2, 24'sd0, 24'sd5);
      send(24'sd0, 24'sd5);
      check_eq("R6 not yet muted", longint'(muted_a), 0);
      send(24'sd0, 24'sd5);
      check_eq("R6 muted at run end", longint'(muted_a), 1);
      check_eq("R8 B independent flag", longint'(muted_b), 0);
      check_eq("R8 B independent data", longint'(out_b), 5);
      send(-24'sd1, 24'sd5);
      check_eq("R9 ones word restarts run", longint'(muted_a), 0);
      send(24'sd0, 24'sd5);
      send(24'sd321, 24'sd5);
      check_eq("R7 release flag", longint'(muted_a), 0);
      check_eq("R7 release data", longint'(out_a), 321);
   endtask

   task automatic t_restart;
      send(24'sd7, 24'sd5);
      stream(5000, 24'sd0, 24'sd5);
      stream(4000, -24'sd1, 24'sd5);
      send(-24'sd1, 24'sd5);
      check_eq("R9 restart no mute", longint'(muted_a), 0);
      check_eq("R9 restart data", longint'(out_a), -1);
   endtask

   task automatic t_disabled;
      send(24'sd7, 24'sd5);
      automute_en = 1'b0;
      stream(RUN + 10, 24'sd0, 24'sd5);
      check_eq("R9 disabled no mute", longint'(muted_a), 0);
      automute_en = 1'b1;
      send(24'sd0, 24'sd5);
      check_eq("R9 full run mutes on enable", longint'(muted_a), 1);
      send(24'sd9, 24'sd5);
      check_eq("R7 release after enable", longint'(out_a), 9);
   endtask

   task automatic finish_run;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_gain();
      t_hold();
      t_trim();
      t_silent_code();
      t_saturate();
      t_manual();
      t_automute();
      t_restart();
      t_disabled();
      finish_run();
   end

endmodule